// File: doc/BRIEF.md
# Seconds Counter with Read Snapshot

This block keeps elapsed time as a 32-bit binary count of seconds. A prescaler divides the incoming oscillator clock, nominally 32.768 kHz, into a one-second tick, and each tick advances the count by one. The count is reached through a small byte-addressed register port that a serial bus slave outside this block drives.

Reads never see the live counter. They are served from a shadow copy, so that a host reading the four count bytes one after another always gets a consistent value. The shadow copy is refreshed only when the bus slave reports one of three events: a transfer start, a transfer stop, or its address pointer wrapping back to zero.

Writes to the three low count bytes are held in a staging register. Writing the top byte moves all 32 bits into the live counter at once and restarts the prescaler. A halt bit in a control byte freezes the prescaler and the count.

Top module: `sec_snapshot_counter`

## Requirements
- R1: While reset is asserted, the live count, the shadow copy and the halt bit are zero, and every address reads 00h.
- R2: With halt at 0, the live count rises by exactly one every TICK_DIV clock cycles. No other change is possible except a load through R7.
- R3: The live count rolls over from FFFFFFFFh to 00000000h and raises no flag.
- R4: Addresses 0, 1, 2 and 3 read bits 7:0, 15:8, 23:16 and 31:24 of the shadow copy, in that order.
- R5: A pulse on bus_start, bus_stop or ptr_wrap copies the live count into the shadow copy. In every other cycle the shadow copy holds its value, and reads do not show later changes of the live count.
- R6: On an edge where a tick and a refresh event fall together, the shadow copy takes the count held before that edge, and the live count still advances.
- R7: Writes to addresses 0 to 2 change only the staging register. A write to address 3 loads the live count with {data, byte 2, byte 1, byte 0} and clears the prescaler, so the next tick comes TICK_DIV cycles later.
- R8: Bit 7 of the control byte at address 7 is the halt bit. When it is 1, the prescaler and the count hold. The byte reads back as {halt, 7'b0}.
- R9: Addresses 4, 5, 6 and 8 up to 15 read 00h, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, divided by TICK_DIV into the one-second tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | One-cycle pulse when a bus transfer begins |
| bus_stop | input | 1 | One-cycle pulse when a bus transfer ends |
| ptr_wrap | input | 1 | One-cycle pulse when the address pointer wraps to 0 |
| addr | input | AW | Register address |
| wr_en | input | 1 | Write strobe for wr_data at addr |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte at addr (combinational) |

## Verification
The checker verifies four rules on every cycle: the shadow copy holds between refresh events, a refresh captures the count from before the edge, the count freezes while halted, and outside a load the count moves by zero or one per cycle. A top-byte write must also leave the written byte on top and the prescaler at zero. The bench scenarios cover the rest. They check the exact TICK_DIV spacing of ticks after a load, the rollover, the byte order, that a partial write is not applied, and the silent addresses. All of these are seen only through reads of the snapshot.

// File: rtl/sec_snapshot_counter.sv
`timescale 1ns/1ps
module sec_snapshot_counter #(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned CW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned CTL_ADDR = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          ptr_wrap,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  localparam int unsigned NB = CW / 8;
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt, shadow;
  logic [CW-9:0] stage;
  logic [PW-1:0] pre;
  logic          halt;

  wire snap = bus_start | bus_stop | ptr_wrap;
  wire load = wr_en && (addr == AW'(NB - 1));
  wire tick = !halt && (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre <= '0;
    else if (load)     pre <= '0;
    else if (!halt)    pre <= tick ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= {wr_data, stage};
    else if (tick)     cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shadow <= '0;
    else if (snap)     shadow <= cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        halt <= 1'b0;
    else if (wr_en && addr == AW'(CTL_ADDR)) halt <= wr_data[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage <= '0;
    else
      for (int i = 0; i < NB - 1; i++)
        if (wr_en && addr == AW'(i)) stage[8*i +: 8] <= wr_data;

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NB; i++)
      if (addr == AW'(i)) rd_data = shadow[8*i +: 8];
    if (addr == AW'(CTL_ADDR)) rd_data = {halt, 7'b0};
  end
endmodule

// File: rtl/sec_snapshot_counter_chk.sv
`timescale 1ns/1ps
module sec_snapshot_counter_chk #(
  parameter int unsigned CW = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          ptr_wrap,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wr_data,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] shadow,
  input logic [PW-1:0] pre,
  input logic          halt
);
  localparam int unsigned NB = CW / 8;
  wire ev = bus_start | bus_stop | ptr_wrap;
  wire ld = wr_en && (addr == AW'(NB - 1));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(shadow));
  // R6
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> shadow == $past(cnt));
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld) |=> $stable(cnt));
  // R7
  load_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt[CW-1:CW-8] == $past(wr_data)) && (pre == '0));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

bind sec_snapshot_counter sec_snapshot_counter_chk #(.CW(CW), .AW(AW), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .ptr_wrap(ptr_wrap), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .cnt(cnt), .shadow(shadow), .pre(pre), .halt(halt));

// File: tb/test_sec_snapshot_counter.sv
`timescale 1ns/100ps
module test_sec_snapshot_counter;
  localparam int DIV = 4;
  localparam logic [31:0] VEC [5] = '{32'h12345678, 32'hFFFFFFFF, 32'h00000001,
                                      32'hA5C30F80, 32'h80000000};
  logic clk = 0, rst_n = 1, bus_start = 0, bus_stop = 0, ptr_wrap = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int errs = 0, checks = 0, nxt = 1;
  logic [31:0] w;

  always #2.5 clk = ~clk;

  sec_snapshot_counter #(.TICK_DIV(DIV)) i_sec_snapshot_counter (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr_wrap(ptr_wrap), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_word(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(i), v[8*i +: 8]);
    nxt = 1;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #0.4; d = rd_data;
  endtask

  task automatic rd_word(output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      rd(4'(i), b); v[8*i +: 8] = b;
    end
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which) 0: bus_start = 1; 1: bus_stop = 1; default: ptr_wrap = 1; endcase
    @(negedge clk); bus_start = 0; bus_stop = 0; ptr_wrap = 0;
  endtask

  task automatic snap_at(int m);
    repeat (m - nxt) @(negedge clk);
    bus_start = 1;
    @(negedge clk); bus_start = 0;
    nxt = m + 1;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    #1 rst_n = 0;
    #1;
    for (int a = 0; a < 16; a++) begin rd(4'(a), b); chk("R1 reset read", 32'(b), 0); end
    #10 @(negedge clk) rst_n = 1;

    wr(4'd7, 8'h80);
    rd(4'd7, b); chk("R8 ctl readback", 32'(b), 32'h80);

    for (int k = 0; k < 5; k++) begin
      wr_word(VEC[k]); pulse(1);
      rd_word(w); chk("R4 R7 byte order", w, VEC[k]);
    end

    wr(4'd0, 8'h44); wr(4'd1, 8'h33); wr(4'd2, 8'h22); pulse(1);
    rd_word(w); chk("R7 partial write not applied", w, 32'h80000000);
    wr(4'd3, 8'h11); pulse(1);
    rd_word(w); chk("R7 atomic load", w, 32'h11223344);

    wr_word(32'hDEADBEEF);
    rd_word(w); chk("R5 no refresh without event", w, 32'h11223344);
    pulse(2);
    rd_word(w); chk("R5 refresh on pointer wrap", w, 32'hDEADBEEF);

    wr(4'd4, 8'hFF); wr(4'd8, 8'hFF); wr(4'd15, 8'hFF);
    rd(4'd4, b); chk("R9 addr 4", 32'(b), 0);
    rd(4'd5, b); chk("R9 addr 5", 32'(b), 0);
    rd(4'd6, b); chk("R9 addr 6", 32'(b), 0);
    rd(4'd8, b); chk("R9 addr 8", 32'(b), 0);
    rd(4'd15, b); chk("R9 addr 15", 32'(b), 0);
    pulse(1); rd_word(w); chk("R9 writes ignored", w, 32'hDEADBEEF);

    repeat (40) @(negedge clk);
    pulse(0); rd_word(w); chk("R8 halted count holds", w, 32'hDEADBEEF);

    wr(4'd7, 8'h00);
    rd(4'd7, b); chk("R8 ctl cleared", 32'(b), 0);

    wr_word(32'd100);
    snap_at(2*DIV);   rd_word(w); chk("R2 one tick", w, 32'd101);
    snap_at(2*DIV+1); rd_word(w); chk("R2 second tick", w, 32'd102);
    snap_at(3*DIV);   rd_word(w); chk("R6 snapshot on tick edge", w, 32'd102);
    snap_at(3*DIV+1); rd_word(w); chk("R6 count advanced", w, 32'd103);

    wr_word(32'hFFFFFFFF);
    snap_at(DIV);   rd_word(w); chk("R3 before rollover", w, 32'hFFFFFFFF);
    snap_at(DIV+1); rd_word(w); chk("R3 rollover", w, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule